// File: doc/BRIEF.md
# Parallel NOR Flash Command Controller

This block is the control logic of a byte-wide parallel NOR flash. A host reaches it over an asynchronous-style bus with chip enable, write enable, output enable, an address and a data byte. The controller samples this bus on its own clock. A write takes effect when write enable rises while chip enable is low. A read takes effect when output enable falls while chip enable is low. Writes are decoded as multi-cycle unlock-and-command sequences. An accepted program or sector-erase command is captured in internal latches, and the bus is free again at once. The selected operation then runs as a self-timed embedded algorithm.

The cell array itself sits outside the block, behind two ports. The first is an engine port with a combinational read and a clocked write. The second is a host read port, which returns the byte at `addr_i` in the same cycle. While an operation runs, reads return polling status in place of data. An erase can be paused so that the host can read or program other sectors, and then resumed. Sectors can be locked by a protection vector, and all writes are refused while the low-supply input is high.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset `dq_o` is 0x00, no array write is issued, and a read of an erased byte returns 0xFF.
- R2: A program runs only after this sequence: 0xAA to address 0x555, then 0x55 to 0x2AA, then 0xA0 to 0x555, then the data to the target. Only the low min(11, ADDR_W) address bits are compared. After completion the target byte holds the old value AND the data, so bits can only go from 1 to 0.
- R3: A sequence with a wrong address or a wrong byte, a sequence broken by 0xF0, or a sequence that is left incomplete issues no array write.
- R4: While a program is busy, every read returns status: bit 7 is the complement of data bit 7, bit 6 flips on each read, and bits 5..0 are 0. Once the program is done, reads return array data.
- R5: A sector erase runs after 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, and then 0x30 to any address in the sector. The sector is given by the top three address bits, and code 7 selects sector 6. The erase first writes 0x00 to every byte of the sector that is not already 0x00. After that, every byte of the sector becomes 0xFF. No other sector changes.
- R6: While an erase runs unsuspended, reads return status: bit 7 is 0 and bit 6 flips on each read.
- R7: A write of 0xB0 to any address during an erase suspends it, and 0x30 to any address resumes it. While suspended:
  - the erase makes no array writes;
  - reads of the erasing sector return a steady 0x80;
  - other sectors read as data and accept programs;
  - a program aimed at the erasing sector is ignored.
  
  After a resume, the erase completes.
- R8: A program or erase aimed at a sector whose `prot_i` bit is set makes no array write.
- R9: While `lvd_i` is high, bus writes are ignored, so a full program sequence issues no array write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low; the write is taken on its rising edge |
| oe_ni | input | 1 | Output enable, active low; the read is taken on its falling edge |
| addr_i | input | ADDR_W | Bus address |
| data_i | input | 8 | Bus write data |
| dq_o | output | 8 | Read data or polling status, held until the next read |
| prot_i | input | 7 | Per-sector write lock |
| lvd_i | input | 1 | Low-supply detect; blocks all writes |
| mem_addr_o | output | ADDR_W | Engine port address |
| mem_we_o | output | 1 | Engine port write strobe |
| mem_wdata_o | output | 8 | Engine port write data |
| mem_rdata_i | input | 8 | Engine port read data for `mem_addr_o`, same cycle |
| host_rdata_i | input | 8 | Array byte at `addr_i`, same cycle |

## Verification
Several properties are checked by assertions on every cycle:
- an erase stays frozen while suspended;
- no array write hits a locked sector, and none issues while suspended;
- the erase walk stays inside its sector and reads back 0xFF in its final pass;
- a program reads back its expected byte;
- a program start is only ever preceded by the data-phase state;
- the low-supply input blocks any start.

Other behaviour can only be shown by the bench's scenarios, because it depends on the contents of the external array over whole command sequences. This covers the AND-merge of programmed data across a sweep of addresses, the exact count of preprogram writes, the status bits seen by the host, and whether untouched sectors keep their contents.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int NUM_SECT = 7;
  localparam int SEC_W    = 3;

  localparam logic [7:0] K_UNL1 = 8'hAA;
  localparam logic [7:0] K_UNL2 = 8'h55;
  localparam logic [7:0] K_PGM  = 8'hA0;
  localparam logic [7:0] K_ESET = 8'h80;
  localparam logic [7:0] K_SERS = 8'h30;
  localparam logic [7:0] K_SUSP = 8'hB0;
  localparam logic [7:0] K_RSM  = 8'h30;
  localparam logic [7:0] K_RST  = 8'hF0;

  typedef enum logic [2:0] {C_IDLE, C_UNL1, C_UNL2, C_PGM, C_ESET, C_E1, C_E2} cmd_st_e;
  typedef enum logic [1:0] {P_IDLE, P_WAIT, P_WR, P_VFY} prog_st_e;
  typedef enum logic [2:0] {E_IDLE, E_PRE, E_WAIT, E_ERS, E_VFY} ers_st_e;

  // top sector code folds onto the last sector
  function automatic logic [SEC_W-1:0] sector_of(input logic [SEC_W-1:0] top);
    return (top > SEC_W'(NUM_SECT-1)) ? SEC_W'(NUM_SECT-1) : top;
  endfunction
endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic                lvd_i,
  input  logic [ADDR_W-1:0]   waddr_i,
  input  logic [7:0]          wdata_i,
  input  logic                prog_busy_i,
  input  logic                ers_active_i,
  input  logic                susp_i,
  input  logic [NUM_SECT-1:0] prot_i,
  input  logic [SEC_W-1:0]    ers_sec_i,
  output logic                pstart_o,
  output logic [ADDR_W-1:0]   paddr_o,
  output logic [7:0]          pdata_o,
  output logic                estart_o,
  output logic [SEC_W-1:0]    esec_o,
  output logic                susp_set_o,
  output logic                resume_o
);
  localparam int CMP_W = (ADDR_W < 11) ? ADDR_W : 11;
  localparam logic [CMP_W-1:0] A_UNL1 = CMP_W'(11'h555);
  localparam logic [CMP_W-1:0] A_UNL2 = CMP_W'(11'h2AA);

  cmd_st_e st_q, st_d;
  logic [CMP_W-1:0] wa;
  logic [SEC_W-1:0] wsec;
  logic wr_ok, ers_run, go_p, go_e, go_s, go_r;

  assign wa      = waddr_i[CMP_W-1:0];
  assign wsec    = sector_of(waddr_i[ADDR_W-1 -: SEC_W]);
  assign wr_ok   = wr_i && !lvd_i && !prog_busy_i && !pstart_o;
  assign ers_run = (ers_active_i || estart_o) && !susp_i;

  always_comb begin
    st_d = st_q;
    go_p = 1'b0;
    go_e = 1'b0;
    go_s = 1'b0;
    go_r = 1'b0;
    if (wr_ok) begin
      if (ers_run) begin
        go_s = (wdata_i == K_SUSP);
        st_d = C_IDLE;
      end else if (wdata_i == K_RST) begin
        st_d = C_IDLE;
      end else if (susp_i && st_q == C_IDLE && wdata_i == K_RSM) begin
        go_r = 1'b1;
      end else begin
        case (st_q)
          C_IDLE, C_ESET: begin
            if (wa == A_UNL1 && wdata_i == K_UNL1) st_d = (st_q == C_IDLE) ? C_UNL1 : C_E1;
            else st_d = C_IDLE;
          end
          C_UNL1, C_E1: begin
            if (wa == A_UNL2 && wdata_i == K_UNL2) st_d = (st_q == C_UNL1) ? C_UNL2 : C_E2;
            else st_d = C_IDLE;
          end
          C_UNL2: begin
            if (wa == A_UNL1 && wdata_i == K_PGM) st_d = C_PGM;
            else if (wa == A_UNL1 && wdata_i == K_ESET && !susp_i) st_d = C_ESET;
            else st_d = C_IDLE;
          end
          C_PGM: begin
            st_d = C_IDLE;
            go_p = !prot_i[wsec] && !(susp_i && wsec == ers_sec_i);
          end
          C_E2: begin
            st_d = C_IDLE;
            go_e = (wdata_i == K_SERS) && !prot_i[wsec];
          end
          default: st_d = C_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= C_IDLE;
      pstart_o   <= 1'b0;
      paddr_o    <= '0;
      pdata_o    <= '0;
      estart_o   <= 1'b0;
      esec_o     <= '0;
      susp_set_o <= 1'b0;
      resume_o   <= 1'b0;
    end else begin
      st_q       <= st_d;
      pstart_o   <= go_p;
      estart_o   <= go_e;
      susp_set_o <= go_s;
      resume_o   <= go_r;
      if (go_p) begin
        paddr_o <= waddr_i;
        pdata_o <= wdata_i;
      end
      if (go_e) esec_o <= wsec;
    end
  end

  p_lvd_no_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvd_i |=> (!pstart_o && !estart_o && st_q == $past(st_q)));

  p_prog_after_seq_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pstart_o |-> ($past(st_q) == C_PGM));

  p_erase_after_seq_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    estart_o |-> ($past(st_q) == C_E2));
endmodule

// File: rtl/flash_prog_engine.sv
module flash_prog_engine
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int PROG_CYC = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i
);
  localparam int CW = $clog2(PROG_CYC + 1);

  prog_st_e st_q;
  logic [CW-1:0] cnt_q;
  logic [ADDR_W-1:0] a_q;
  logic [7:0] d_q, exp_q;

  assign busy_o      = (st_q != P_IDLE);
  assign mem_addr_o  = a_q;
  assign mem_we_o    = (st_q == P_WR);
  assign mem_wdata_o = mem_rdata_i & d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= P_IDLE;
      cnt_q <= '0;
      a_q   <= '0;
      d_q   <= '0;
      exp_q <= '0;
    end else begin
      case (st_q)
        P_IDLE: if (start_i) begin
          a_q   <= addr_i;
          d_q   <= data_i;
          cnt_q <= CW'(PROG_CYC - 1);
          st_q  <= P_WAIT;
        end
        P_WAIT: if (cnt_q == '0) st_q <= P_WR;
                else cnt_q <= cnt_q - 1'b1;
        P_WR: begin
          exp_q <= mem_rdata_i & d_q;
          st_q  <= P_VFY;
        end
        P_VFY: st_q <= (mem_rdata_i == exp_q) ? P_IDLE : P_WR;
        default: st_q <= P_IDLE;
      endcase
    end
  end

  p_verify_match_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == P_VFY) |-> (mem_rdata_i == exp_q));
endmodule

// File: rtl/flash_erase_engine.sv
module flash_erase_engine
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int ERASE_CYC = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SEC_W-1:0]  sec_i,
  input  logic              susp_i,
  output logic              active_o,
  output logic [SEC_W-1:0]  sec_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i
);
  localparam int SH = ADDR_W - SEC_W;
  localparam int CW = $clog2(ERASE_CYC + 1);

  ers_st_e st_q;
  logic [CW-1:0] cnt_q;
  logic [SEC_W-1:0] sec_q;
  logic [ADDR_W-1:0] ptr_q, base, last;
  logic at_last;

  assign base    = {sec_q, {SH{1'b0}}};
  assign last    = (sec_q == SEC_W'(NUM_SECT-1)) ? '1 : {sec_q, {SH{1'b1}}};
  assign at_last = (ptr_q == last);

  assign active_o    = (st_q != E_IDLE);
  assign sec_o       = sec_q;
  assign mem_addr_o  = ptr_q;
  assign mem_we_o    = !susp_i && ((st_q == E_PRE && mem_rdata_i != 8'h00) || st_q == E_ERS);
  assign mem_wdata_o = (st_q == E_ERS) ? 8'hFF : 8'h00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= E_IDLE;
      cnt_q <= '0;
      sec_q <= '0;
      ptr_q <= '0;
    end else if (st_q == E_IDLE) begin
      if (start_i) begin
        sec_q <= sec_i;
        ptr_q <= {sec_i, {SH{1'b0}}};
        st_q  <= E_PRE;
      end
    end else if (!susp_i) begin
      case (st_q)
        E_PRE: if (at_last) begin
          ptr_q <= base;
          cnt_q <= CW'(ERASE_CYC - 1);
          st_q  <= E_WAIT;
        end else ptr_q <= ptr_q + ADDR_W'(1);
        E_WAIT: if (cnt_q == '0) st_q <= E_ERS;
                else cnt_q <= cnt_q - 1'b1;
        E_ERS: if (at_last) begin
          ptr_q <= base;
          st_q  <= E_VFY;
        end else ptr_q <= ptr_q + ADDR_W'(1);
        E_VFY: if (at_last) st_q <= E_IDLE;
               else ptr_q <= ptr_q + ADDR_W'(1);
        default: st_q <= E_IDLE;
      endcase
    end
  end

  p_freeze_susp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (susp_i && st_q != E_IDLE) |=> (st_q == $past(st_q) && ptr_q == $past(ptr_q)));

  p_walk_in_sector_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != E_IDLE) |-> (ptr_q >= base && ptr_q <= last));

  p_final_pass_ff_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == E_VFY && !susp_i) |-> (mem_rdata_i == 8'hFF));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int PROG_CYC  = 64,
  parameter int ERASE_CYC = 1024
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ce_ni,
  input  logic                we_ni,
  input  logic                oe_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [7:0]          data_i,
  output logic [7:0]          dq_o,
  input  logic [NUM_SECT-1:0] prot_i,
  input  logic                lvd_i,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic                mem_we_o,
  output logic [7:0]          mem_wdata_o,
  input  logic [7:0]          mem_rdata_i,
  input  logic [7:0]          host_rdata_i
);
  logic we_q, oe_q, wr_ev, rd_ev, susp_q, tog_q;
  logic p_start, p_busy, e_start, e_active, susp_set, resume;
  logic [ADDR_W-1:0] p_addr, p_maddr, e_maddr;
  logic [7:0] p_data, p_wdata, e_wdata;
  logic [SEC_W-1:0] e_sec_cmd, e_sec;
  logic p_we, e_we;

  assign wr_ev = !ce_ni && we_ni && !we_q;
  assign rd_ev = !ce_ni && !oe_ni && oe_q;

  flash_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_ev), .lvd_i(lvd_i),
    .waddr_i(addr_i), .wdata_i(data_i), .prog_busy_i(p_busy),
    .ers_active_i(e_active), .susp_i(susp_q), .prot_i(prot_i), .ers_sec_i(e_sec),
    .pstart_o(p_start), .paddr_o(p_addr), .pdata_o(p_data),
    .estart_o(e_start), .esec_o(e_sec_cmd), .susp_set_o(susp_set), .resume_o(resume)
  );

  flash_prog_engine #(.ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC)) u_prog (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(p_start), .addr_i(p_addr),
    .data_i(p_data), .busy_o(p_busy), .mem_addr_o(p_maddr), .mem_we_o(p_we),
    .mem_wdata_o(p_wdata), .mem_rdata_i(mem_rdata_i)
  );

  flash_erase_engine #(.ADDR_W(ADDR_W), .ERASE_CYC(ERASE_CYC)) u_ers (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(e_start), .sec_i(e_sec_cmd),
    .susp_i(susp_q), .active_o(e_active), .sec_o(e_sec), .mem_addr_o(e_maddr),
    .mem_we_o(e_we), .mem_wdata_o(e_wdata), .mem_rdata_i(mem_rdata_i)
  );

  // program engine owns the array port whenever it runs
  assign mem_addr_o  = p_busy ? p_maddr : e_maddr;
  assign mem_we_o    = p_busy ? p_we    : e_we;
  assign mem_wdata_o = p_busy ? p_wdata : e_wdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q   <= 1'b1;
      oe_q   <= 1'b1;
      susp_q <= 1'b0;
      tog_q  <= 1'b0;
      dq_o   <= 8'h00;
    end else begin
      we_q <= we_ni;
      oe_q <= oe_ni;
      if (!e_active)    susp_q <= 1'b0;
      else if (susp_set) susp_q <= 1'b1;
      else if (resume)   susp_q <= 1'b0;
      if (rd_ev) begin
        if (p_busy || p_start) begin
          dq_o  <= {~p_data[7], tog_q, 6'b0};
          tog_q <= ~tog_q;
        end else if ((e_active || e_start) && !susp_q) begin
          dq_o  <= {1'b0, tog_q, 6'b0};
          tog_q <= ~tog_q;
        end else if (e_active && sector_of(addr_i[ADDR_W-1 -: SEC_W]) == e_sec) begin
          dq_o <= 8'h80;
        end else begin
          dq_o <= host_rdata_i;
        end
      end
    end
  end

  p_no_locked_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !prot_i[sector_of(mem_addr_o[ADDR_W-1 -: SEC_W])]);

  p_quiet_in_susp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (susp_q && !p_busy) |-> !mem_we_o);
endmodule

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce = 1'b1, we = 1'b1, oe = 1'b1, lvd = 1'b0;
  logic [AW-1:0] addr = '0, mem_addr;
  logic [7:0] data = '0, dq, mem_wdata, mem_rdata, host_rdata;
  logic [6:0] prot = 7'b0001000;
  logic mem_we;
  logic [7:0] mem [256];
  logic [7:0] model [256];
  int checks = 0, fails = 0, nwr = 0, nzero = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(AW), .PROG_CYC(8), .ERASE_CYC(16)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce), .we_ni(we), .oe_ni(oe),
    .addr_i(addr), .data_i(data), .dq_o(dq), .prot_i(prot), .lvd_i(lvd),
    .mem_addr_o(mem_addr), .mem_we_o(mem_we), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .host_rdata_i(host_rdata)
  );

  assign mem_rdata  = mem[mem_addr];
  assign host_rdata = mem[addr];

  always @(posedge clk) if (mem_we) begin
    mem[mem_addr] <= mem_wdata;
    nwr = nwr + 1;
    if (mem_wdata == 8'h00) nzero = nzero + 1;
  end

  function automatic int sect(input int a);
    return ((a >> 5) > 6) ? 6 : (a >> 5);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; data = d; ce = 1'b0; we = 1'b0;
    @(negedge clk); we = 1'b1;
    @(negedge clk); ce = 1'b1;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; ce = 1'b0; oe = 1'b0;
    @(negedge clk); d = dq; oe = 1'b1; ce = 1'b1;
  endtask

  task automatic poll(input logic [7:0] a);
    logic [7:0] x, y;
    for (int i = 0; i < 3000; i++) begin
      rd(a, x); rd(a, y);
      if (x == y) break;
    end
  endtask

  task automatic cmd_prog(input logic [7:0] a, input logic [7:0] d);
    wr(8'h55, 8'hAA); wr(8'hAA, 8'h55); wr(8'h55, 8'hA0); wr(a, d);
  endtask

  task automatic cmd_erase(input int s);
    wr(8'h55, 8'hAA); wr(8'hAA, 8'h55); wr(8'h55, 8'h80);
    wr(8'h55, 8'hAA); wr(8'hAA, 8'h55); wr(8'(s << 5), 8'h30);
  endtask

  task automatic cmp_all(input string req);
    int bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== model[i]) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [7:0] s1, s2, v;
    int n0, nz, z0;
    for (int i = 0; i < 256; i++) begin mem[i] = 8'hFF; model[i] = 8'hFF; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(dq == 8'h00, "R1 dq after reset", dq, 0);
    chk(mem_we == 1'b0, "R1 no array write", mem_we, 0);
    rd(8'h00, v);
    chk(v == 8'hFF, "R1 erased read", v, 8'hFF);

    // R2 R4 program sweep, two passes so bits merge by AND
    for (int pass = 0; pass < 2; pass++) begin
      for (int a = pass; a < 256; a += 7 + 6 * pass) begin
        logic [7:0] d;
        if (sect(a) == 3) continue;
        d = (pass == 0) ? 8'((a * 29 + 5) & 8'hFF) : 8'(~a);
        cmd_prog(8'(a), d);
        rd(8'(a), s1);
        chk(s1 == {~d[7], s1[6], 6'b0}, "R4 program status bits", s1, {~d[7], s1[6], 6'b0});
        rd(8'(a), s2);
        chk(s2[6] != s1[6], "R4 toggle per read", s2, s1 ^ 8'h40);
        poll(8'(a));
        model[a] = model[a] & d;
        rd(8'(a), v);
        chk(v == model[a], "R2 programmed byte", v, model[a]);
      end
    end
    cmp_all("R2 array after sweep");

    // R3 broken sequences
    n0 = nwr;
    wr(8'h55, 8'hAA); wr(8'hAB, 8'h55); wr(8'h55, 8'hA0); wr(8'h10, 8'h00);
    wr(8'h55, 8'hAA); wr(8'h55, 8'hF0); wr(8'hAA, 8'h55); wr(8'h55, 8'hA0); wr(8'h10, 8'h00);
    wr(8'h55, 8'hAA); wr(8'hAA, 8'h55); wr(8'h55, 8'hA1); wr(8'h10, 8'h00);
    wr(8'h55, 8'hAA); wr(8'hAA, 8'h55); wr(8'h55, 8'hA0); wr(8'h10, 8'hF0);
    repeat (20) @(negedge clk);
    chk(nwr == n0, "R3 no write from bad sequences", nwr - n0, 0);
    rd(8'h10, v);
    chk(v == model[8'h10], "R3 byte untouched", v, model[8'h10]);

    // R9 low supply
    lvd = 1'b1;
    cmd_prog(8'h11, 8'h00);
    lvd = 1'b0;
    repeat (20) @(negedge clk);
    chk(nwr == n0, "R9 no write under low supply", nwr - n0, 0);
    rd(8'h11, v);
    chk(v == model[8'h11], "R9 byte untouched", v, model[8'h11]);

    // R8 locked sector 3
    cmd_prog(8'h65, 8'h00);
    repeat (20) @(negedge clk);
    cmd_erase(3);
    repeat (60) @(negedge clk);
    chk(nwr == n0, "R8 no write to locked sector", nwr - n0, 0);
    rd(8'h65, v);
    chk(v == 8'hFF, "R8 locked byte", v, 8'hFF);

    // R5 R6 erase sector 1
    nz = 0;
    for (int i = 32; i < 64; i++) if (model[i] != 8'h00) nz++;
    z0 = nzero;
    cmd_erase(1);
    rd(8'h20, s1);
    chk(s1 == {1'b0, s1[6], 6'b0}, "R6 erase status bits", s1, {1'b0, s1[6], 6'b0});
    rd(8'h20, s2);
    chk(s2[6] != s1[6], "R6 toggle per read", s2, s1 ^ 8'h40);
    poll(8'h20);
    chk(nzero - z0 == nz, "R5 preprogram write count", nzero - z0, nz);
    for (int i = 32; i < 64; i++) model[i] = 8'hFF;
    cmp_all("R5 sector erased others kept");

    // R7 suspend and resume on sector 6
    cmd_erase(6);
    wr(8'h00, 8'hB0);
    repeat (4) @(negedge clk);
    n0 = nwr;
    repeat (40) @(negedge clk);
    chk(nwr == n0, "R7 erase frozen", nwr - n0, 0);
    rd(8'hC5, s1);
    chk(s1 == 8'h80, "R7 erasing sector read", s1, 8'h80);
    rd(8'hC5, s2);
    chk(s2 == 8'h80, "R7 steady suspend status", s2, 8'h80);
    rd(8'h02, v);
    chk(v == model[2], "R7 other sector data", v, model[2]);
    cmd_prog(8'hC7, 8'h00);
    repeat (20) @(negedge clk);
    chk(nwr == n0, "R7 program to erasing sector ignored", nwr - n0, 0);
    cmd_prog(8'h03, 8'h0F);
    rd(8'h03, s1);
    chk(s1[7] == 1'b1, "R7 R4 status during suspend", s1, 8'h80);
    poll(8'h03);
    model[3] = model[3] & 8'h0F;
    rd(8'h03, v);
    chk(v == model[3], "R7 program in suspend", v, model[3]);
    wr(8'h00, 8'h30);
    poll(8'hC0);
    for (int i = 192; i < 256; i++) model[i] = 8'hFF;
    cmp_all("R7 erase completes after resume");

    done = 1;
    finish_run();
  end
endmodule